// File: doc/BRIEF.md
# Half-duplex two-wire register port

This block is the device side of a two-wire serial link. The host drives a clock (`sck`) and shares one bidirectional data line with the device. Each transaction is exactly sixteen host clock cycles long. The block decodes each transaction into a read or a write of a small bank of 8-bit registers.

The bank holds:
- a configuration register, with soft-reset, power-down and forced-awake bits;
- a status register, which reports the awake flag;
- two signed motion counts that clear when read;
- a fixed identity-complement register.

The block runs on the system clock `clk`. The host clock and data line are brought in through a two-stage synchronizer. The block drives the output enable of the data pad itself. It passes the line from host to device after the address, and back again after the data.

Motion arrives as single-cycle step pulses, each with a direction bit. A transaction watchdog, clocked by the system clock, drops a transaction that stalls so that the host can get back in step.

Top module: `serial_reg_port`

## Requirements
- R1: A transaction is 16 `sck` rising edges, sampled by the device. The fields are sent in this order: one direction bit (1 = write, 0 = read), then a 7-bit address MSB first, then 8 data bits MSB first. A write to address 0x00 stores the data, and a later read of 0x00 returns it.
- R2: On a read, `sdio_oe` stays 0 through the direction and address bits. The device drives data bit 7 from the first `sck` falling edge after the 8th rising edge, and drives each following bit on each following falling edge. After the 16th rising edge it keeps `sdio_oe`=1 with bit 0 on `sdio_out` until the next falling edge, then sets `sdio_oe` to 0.
- R3: A transaction that has not reached its 16th rising edge WDOG_LIMIT system clock cycles after its first rising edge is abandoned. The next full transaction is then decoded correctly, and the abandoned one has no effect.
- R4: A write to any address other than 0x00 changes no register. A read of an address other than 0x00, 0x01, 0x02, 0x03 and 0x11 returns 0x00. A read of 0x11 returns 0xFF.
- R5: After reset the configuration register reads 0x00. Output `pdown` follows configuration bit 6 and output `force_awake` follows configuration bit 0.
- R6: A write to 0x00 with bit 7 set clears both motion counts. The configuration register stores the other seven bits and reads bit 7 back as 0.
- R7: While bit 6 is set, a write to 0x00 updates only bit 6, `sdio_oe` stays 0 (the line floats), and the watchdog does not count.
- R8: Address 0x01 reads `{7'b0000000, awake_in}`. It reads 0x01 when `awake_in` is 1.
- R9: Address 0x03 holds the X count and address 0x02 the Y count, both 8-bit two's complement. Each step pulse adds +1 (`*_neg`=0) or -1 (`*_neg`=1). Reading a count returns its value and clears it.
- R10: The counts saturate at +127 (0x7F) and -128 (0x80) and never wrap.
- R11: A step pulse in the same cycle as the clearing read is kept: it becomes the first step of the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Host serial clock, idles high |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data driven by the device |
| sdio_oe | output | 1 | Device drives the data line when 1 |
| awake_in | input | 1 | Awake flag shown in status bit 0 |
| mx_step | input | 1 | X motion step pulse |
| mx_neg | input | 1 | X step direction, 1 = negative |
| my_step | input | 1 | Y motion step pulse |
| my_neg | input | 1 | Y step direction, 1 = negative |
| pdown | output | 1 | Configuration bit 6 (power-down) |
| force_awake | output | 1 | Configuration bit 0 (forced awake) |

## Verification
The device sees each `sck` edge three system clocks after the pin changes: two synchronizer stages plus the edge register.

A write therefore takes effect three clocks after the 16th rising edge, so the bench waits twenty clocks before it looks at `pdown` or `force_awake`. A read byte is captured at the 8th rising edge, and each data bit is updated three clocks after a falling edge. The monitor samples every bit at the host's rising edge, eight clocks later.

Timeout checks wait WDOG_LIMIT plus a margin before the next transaction. The same-cycle carry check does not depend on the exact clear cycle. It holds a step pulse high across the capture window and checks that the two reads together add up to the number of pulses.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int         WDOG_LIMIT = 2160000,
  parameter logic [7:0] INV_ID     = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  input  logic awake_in,
  input  logic mx_step,
  input  logic mx_neg,
  input  logic my_step,
  input  logic my_neg,
  output logic pdown,
  output logic force_awake
);
  localparam int WDW = $clog2(WDOG_LIMIT + 1);
  localparam logic [6:0] A_CFG = 7'h00, A_STAT = 7'h01, A_DY = 7'h02,
                         A_DX = 7'h03, A_INV = 7'h11;

  logic [2:0] sck_q;
  logic [1:0] din_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 3'b111;
      din_q <= 2'b11;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      din_q <= {din_q[0], sdio_in};
    end

  wire rise = sck_q[1] & ~sck_q[2];
  wire fall = ~sck_q[1] & sck_q[2];
  wire din  = din_q[1];

  logic [4:0]     cnt;
  logic           dir_wr;
  logic [6:0]     addr;
  logic [6:0]     dsh;
  logic [7:0]     rbuf;
  logic           oe_q, dout_q;
  logic [WDW-1:0] wd;
  logic [7:0]     cfg;
  logic signed [7:0] dx, dy;
  logic [7:0]     rsel;

  wire [6:0] addr_nx = {addr[5:0], din};
  wire [7:0] wdata   = {dsh, din};
  wire rd_cap  = rise && cnt == 5'd7 && !dir_wr;
  wire wr_hit  = rise && cnt == 5'd15 && dir_wr;
  wire cfg_wr  = wr_hit && addr == A_CFG;
  wire srst    = cfg_wr && !cfg[6] && wdata[7];
  wire timeout = cnt != 5'd0 && !cfg[6] && wd == WDW'(WDOG_LIMIT - 1);
  wire clr_x   = (rd_cap && addr_nx == A_DX) || srst;
  wire clr_y   = (rd_cap && addr_nx == A_DY) || srst;

  always_comb
    case (addr_nx)
      A_CFG:   rsel = cfg;
      A_STAT:  rsel = {7'b0000000, awake_in};
      A_DY:    rsel = dy;
      A_DX:    rsel = dx;
      A_INV:   rsel = INV_ID;
      default: rsel = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; dir_wr <= 1'b0; addr <= '0; dsh <= '0;
      rbuf <= '0; oe_q <= 1'b0; dout_q <= 1'b0; wd <= '0;
    end else begin
      if (timeout) cnt <= '0;
      else if (rise) begin
        if (cnt == 5'd0) begin
          dir_wr <= din;
          cnt    <= 5'd1;
        end else if (cnt < 5'd8) begin
          addr <= addr_nx;
          cnt  <= cnt + 5'd1;
          if (cnt == 5'd7 && !dir_wr) rbuf <= rsel;
        end else begin
          dsh <= wdata[6:0];
          cnt <= (cnt == 5'd15) ? 5'd0 : cnt + 5'd1;
        end
      end
      if (fall) begin
        if (!dir_wr && cnt >= 5'd8) begin
          dout_q <= rbuf[7];
          rbuf   <= {rbuf[6:0], 1'b0};
          oe_q   <= 1'b1;
        end else oe_q <= 1'b0;
      end
      if (timeout) oe_q <= 1'b0;
      if (cnt == 5'd0 || timeout) wd <= '0;
      else if (!cfg[6]) wd <= wd + WDW'(1);
    end

  function automatic logic signed [7:0] step_sat(input logic signed [7:0] b,
                                                 input logic s, input logic n);
    if (!s) return b;
    if (n) return (b == -8'sd128) ? b : b - 8'sd1;
    return (b == 8'sd127) ? b : b + 8'sd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= 8'h00; dx <= '0; dy <= '0;
    end else begin
      if (cfg_wr) begin
        if (cfg[6]) cfg[6] <= wdata[6];
        else        cfg    <= {1'b0, wdata[6:0]};
      end
      dx <= step_sat(clr_x ? 8'sd0 : dx, mx_step, mx_neg);
      dy <= step_sat(clr_y ? 8'sd0 : dy, my_step, my_neg);
    end

  assign sdio_oe     = oe_q & ~cfg[6];
  assign sdio_out    = dout_q;
  assign pdown       = cfg[6];
  assign force_awake = cfg[0];

  assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > 5'd0 && cnt < 5'd8) |-> !sdio_oe);
  assert_timeout_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> cnt == 5'd0);
  assert_pd_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg[6]) |=> cfg[5:0] == $past(cfg[5:0]));
  assert_pd_wd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[6] && cnt != 5'd0 && !rise) |=> $stable(wd));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dx == 8'sd127 && !clr_x) |=> dx != -8'sd128);
  assert_no_wrap_neg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dy == -8'sd128 && !clr_y) |=> dy != 8'sd127);
  assert_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_x && !srst && mx_step) |=> dx == ($past(mx_neg) ? -8'sd1 : 8'sd1));
endmodule

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int HALF = 8;
  localparam int WDL  = 300;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b1;
  logic host_drv = 1'b0, host_bit = 1'b1;
  logic awake_in = 1'b1, mx_step = 1'b0, mx_neg = 1'b0, my_step = 1'b0, my_neg = 1'b0;
  logic sdio_out, sdio_oe, pdown, force_awake;
  wire  bus = sdio_oe ? sdio_out : (host_drv ? host_bit : 1'b1);

  always #5 clk = ~clk;

  serial_reg_port #(.WDOG_LIMIT(WDL)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdio_in(bus), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .awake_in(awake_in), .mx_step(mx_step), .mx_neg(mx_neg),
    .my_step(my_step), .my_neg(my_neg), .pdown(pdown), .force_awake(force_awake));

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int mon_cnt = 0;
  bit mon_rd = 1'b0;
  logic [7:0] mon_sh, mon_byte;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge sck) begin
    mon_cnt++;
    if (mon_rd && mon_cnt == 4) chk(!sdio_oe, "R2 oe during address", sdio_oe, 0);
    if (mon_rd && mon_cnt >= 9) mon_sh = {mon_sh[6:0], bus};
    if (mon_rd && mon_cnt == 16) begin
      int e;
      string t;
      mon_byte = mon_sh;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e >= 0) chk(mon_sh == e[7:0], t, mon_sh, e);
    end
  end

  task automatic run_bits(logic [15:0] f, int first, int last);
    bit rd = ~f[15];
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      sck = 1'b0;
      host_drv = (!rd || i <= 8);
      host_bit = f[16-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    host_drv = 1'b0;
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    mon_cnt = 0; mon_rd = 1'b0;
    run_bits({1'b1, a, d}, 1, 16);
    repeat (20) @(negedge clk);
  endtask

  task automatic rd(logic [6:0] a, int exp, string tag);
    mon_cnt = 0; mon_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    run_bits({1'b0, a, 8'h00}, 1, 16);
  endtask

  task automatic pulse_x(int n, bit neg);
    repeat (n) begin
      @(negedge clk); mx_step = 1'b1; mx_neg = neg;
      @(negedge clk); mx_step = 1'b0;
    end
  endtask

  task automatic pulse_y(int n, bit neg);
    repeat (n) begin
      @(negedge clk); my_step = 1'b1; my_neg = neg;
      @(negedge clk); my_step = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v1, v2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdio_oe, "R5 reset oe", sdio_oe, 0);
    chk(!pdown && !force_awake, "R5 reset cfg outputs", {pdown, force_awake}, 0);
    rd(7'h00, 8'h00, "R5 cfg reset value");
    rd(7'h01, 8'h01, "R8 status");
    rd(7'h11, 8'hFF, "R4 inverse id");

    wr(7'h00, 8'h01);
    chk(force_awake, "R5 force_awake", force_awake, 1);
    rd(7'h00, 8'h01, "R1 cfg readback");
    wr(7'h00, 8'h3C);
    chk(!force_awake && !pdown, "R5 cfg outputs", {pdown, force_awake}, 0);
    rd(7'h00, 8'h3C, "R1 cfg readback 3C");

    wr(7'h05, 8'hAA);
    rd(7'h05, 8'h00, "R4 unmapped read");
    rd(7'h00, 8'h3C, "R4 unmapped write no effect");

    pulse_x(5, 1'b0);
    rd(7'h03, 8'h05, "R9 dx +5");
    rd(7'h03, 8'h00, "R9 dx cleared");
    pulse_y(3, 1'b1);
    rd(7'h02, 8'hFD, "R9 dy -3");

    pulse_x(200, 1'b0);
    rd(7'h03, 8'h7F, "R10 dx sat +127");
    pulse_y(150, 1'b1);
    rd(7'h02, 8'h80, "R10 dy sat -128");

    fork
      rd(7'h02, -1, "R11 first");
      begin
        wait (mon_cnt == 7);
        repeat (4) @(negedge clk);
        my_step = 1'b1; my_neg = 1'b0;
        repeat (20) @(negedge clk);
        my_step = 1'b0;
      end
    join
    v1 = mon_byte;
    repeat (10) @(negedge clk);
    rd(7'h02, -1, "R11 second");
    v2 = mon_byte;
    chk(v1 + v2 == 20, "R11 carry on clear", v1 + v2, 20);

    rd(7'h01, 8'h01, "R2 status read");
    chk(sdio_oe && sdio_out, "R2 hold D0", {sdio_oe, sdio_out}, 3);
    @(negedge clk); sck = 1'b0;
    repeat (6) @(negedge clk);
    chk(!sdio_oe, "R2 release after fall", sdio_oe, 0);
    repeat (HALF - 6) @(negedge clk);
    sck = 1'b1;
    repeat (WDL + 40) @(negedge clk);
    rd(7'h00, 8'h3C, "R3 resync after stray edge");

    mon_cnt = 0; mon_rd = 1'b0;
    run_bits({1'b1, 7'h00, 8'h41}, 1, 6);
    repeat (WDL + 40) @(negedge clk);
    rd(7'h00, 8'h3C, "R3 partial write dropped");
    chk(!pdown, "R3 partial no pdown", pdown, 0);

    pulse_x(4, 1'b0);
    wr(7'h00, 8'h81);
    rd(7'h00, 8'h01, "R6 reset bit self-clear");
    rd(7'h03, 8'h00, "R6 dx cleared");
    chk(force_awake, "R6 other bits stored", force_awake, 1);

    wr(7'h00, 8'h40);
    chk(pdown && !force_awake, "R7 enter pdown", {pdown, force_awake}, 2);
    rd(7'h01, 8'hFF, "R7 line floats in pdown");
    wr(7'h00, 8'h41);
    chk(pdown && !force_awake, "R7 only bit6 written", {pdown, force_awake}, 2);
    mon_cnt = 0; mon_rd = 1'b0;
    run_bits({1'b1, 7'h00, 8'h00}, 1, 8);
    repeat (2 * WDL) @(negedge clk);
    run_bits({1'b1, 7'h00, 8'h00}, 9, 16);
    repeat (20) @(negedge clk);
    chk(!pdown, "R7 watchdog stopped in pdown", pdown, 0);
    rd(7'h00, 8'h00, "R7 cfg after exit");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all reads seen", exp_q.size(), 0);
    finish_run();
  end
endmodule